// File: doc/BRIEF.md
# Hot-Plug Slot Controller

This block holds the slot-side hot-plug state of one downstream port that accepts removable modules. It takes a raw presence-detect level from the physical layer and a raw attention-button level. It brings both into the clock domain and filters them over a programmable number of cycles. From the filtered levels it keeps a live presence-state bit and two sticky event bits: one for a presence change and one for a button press.

Software-side logic around the block provides enable bits and write-one-to-clear strobes. The block combines the sticky events with their per-event enables and a global hot-plug enable to drive one level-sensitive interrupt. Two 2-bit command fields drive an attention indicator and a power indicator. Each indicator can be on, off, or blinking at a rate taken from a clock divider.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset, status_o is 3'b000, both indicator outputs are 0 and irq_o is 0.
- R2: presence_i and button_i pass through a two-flop synchronizer and a debounce filter. A new level held for fewer than deb_cycles_i clock cycles is ignored. A level held for deb_cycles_i + 3 cycles or more is accepted.
- R3: When the filtered presence is 1 and power_ok_i is 1, status_o[0] (presence state) becomes 1. The change also sets status_o[1] (presence changed).
- R4: When the filtered presence drops to 0, or power_ok_i drops to 0, status_o[0] becomes 0 and status_o[1] is set. status_o[0] is 0 one cycle after any cycle with power_ok_i low.
- R5: A filtered rising edge of the button sets status_o[2] (button pressed). Releasing the button does not set it.
- R6: status_o[1] and status_o[2] are sticky. A one-cycle pulse on clr_pdc_i or clr_abp_i clears the matching bit on the next edge. A new event in the same cycle as its clear leaves the bit set.
- R7: irq_o = hp_en_i & ((status_o[1] & pd_en_i) | (status_o[2] & ab_en_i)). It is combinational from the registered status and the enables.
- R8: Indicator command codes are 2'b01 on, 2'b11 off, 2'b10 blink. The code 2'b00 keeps the previous indicator state. The output follows a new command one cycle later.
- R9: In blink state an indicator output toggles once every BLINK_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presence_i | input | 1 | Raw module presence from the physical layer |
| power_ok_i | input | 1 | Slot power present |
| button_i | input | 1 | Raw attention button level |
| deb_cycles_i | input | CNT_W | Debounce length in cycles |
| hp_en_i | input | 1 | Global hot-plug interrupt enable |
| pd_en_i | input | 1 | Presence-change interrupt enable |
| ab_en_i | input | 1 | Button-press interrupt enable |
| clr_pdc_i | input | 1 | Write-one-to-clear for presence changed |
| clr_abp_i | input | 1 | Write-one-to-clear for button pressed |
| attn_cmd_i | input | 2 | Attention indicator command |
| pwr_cmd_i | input | 2 | Power indicator command |
| status_o | output | 3 | {button pressed, presence changed, presence state} |
| attn_led_o | output | 1 | Attention indicator drive |
| pwr_led_o | output | 1 | Power indicator drive |
| irq_o | output | 1 | Slot interrupt |

## Verification
The hardest case to reach from the ports is a new event landing in the same cycle as the clear strobe for that event. The exact edge depends on the synchronizer and debounce depth. The bench holds clr_pdc_i high across a whole presence transition instead of timing a pulse. With the clear held, the presence-changed bit must still be seen high for a cycle and must then fall. The debounce filter gets a glitch shorter than the programmed length, and the bench checks that it leaves every status bit unchanged.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic [1:0] {
    IND_OFF   = 2'd0,
    IND_ON    = 2'd1,
    IND_BLINK = 2'd2
  } ind_state_e;

  localparam logic [1:0] CMD_HOLD  = 2'b00;
  localparam logic [1:0] CMD_ON    = 2'b01;
  localparam logic [1:0] CMD_BLINK = 2'b10;
  localparam logic [1:0] CMD_OFF   = 2'b11;

  localparam int unsigned ST_PDS = 0;
  localparam int unsigned ST_PDC = 1;
  localparam int unsigned ST_ABP = 2;
  localparam int unsigned ST_W   = 3;
endpackage

// File: rtl/hp_debounce.sv
module hp_debounce #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             level_o
);
  logic             sync1_q, sync2_q, stable_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q  <= 1'b0;
      sync2_q  <= 1'b0;
      stable_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      sync1_q <= raw_i;
      sync2_q <= sync1_q;
      if (sync2_q == stable_q) begin
        cnt_q <= '0;
      end else if (cnt_inc >= {1'b0, len_i}) begin
        stable_q <= sync2_q;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_inc[CNT_W-1:0];
      end
    end
  end

  assign level_o = stable_q;
endmodule

// File: rtl/hp_blink_div.sv
module hp_blink_div #(
  parameter int unsigned DIV = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic phase_o
);
  localparam int unsigned DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] cnt_q;
  logic             phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/hp_indicator.sv
module hp_indicator
  import hp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cmd_i,
  input  logic       phase_i,
  output logic       led_o
);
  ind_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= IND_OFF;
    end else begin
      unique case (cmd_i)
        CMD_ON:    state_q <= IND_ON;
        CMD_BLINK: state_q <= IND_BLINK;
        CMD_OFF:   state_q <= IND_OFF;
        default:   state_q <= state_q;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      IND_ON:    led_o = 1'b1;
      IND_BLINK: led_o = phase_i;
      default:   led_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned BLINK_DIV = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             presence_i,
  input  logic             power_ok_i,
  input  logic             button_i,
  input  logic [CNT_W-1:0] deb_cycles_i,
  input  logic             hp_en_i,
  input  logic             pd_en_i,
  input  logic             ab_en_i,
  input  logic             clr_pdc_i,
  input  logic             clr_abp_i,
  input  logic [1:0]       attn_cmd_i,
  input  logic [1:0]       pwr_cmd_i,
  output logic [ST_W-1:0]  status_o,
  output logic             attn_led_o,
  output logic             pwr_led_o,
  output logic             irq_o
);
  localparam int unsigned N_IN  = 2;
  localparam int unsigned N_IND = 2;

  logic [N_IN-1:0]      raw_in, flt_in;
  logic [N_IND-1:0][1:0] ind_cmd;
  logic [N_IND-1:0]     ind_led;
  logic                 blink_phase;

  logic pds_q, pdc_q, abp_q, btn_prev_q;
  logic pres_ok, pds_evt, abp_evt;

  assign raw_in = {button_i, presence_i};

  for (genvar g = 0; g < N_IN; g++) begin : g_deb
    hp_debounce #(.CNT_W(CNT_W)) u_deb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw_in[g]),
      .len_i  (deb_cycles_i),
      .level_o(flt_in[g])
    );
  end

  // presence only counts while slot power is present
  assign pres_ok = flt_in[0] & power_ok_i;
  assign pds_evt = pres_ok != pds_q;
  assign abp_evt = flt_in[1] & ~btn_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pds_q      <= 1'b0;
      pdc_q      <= 1'b0;
      abp_q      <= 1'b0;
      btn_prev_q <= 1'b0;
    end else begin
      pds_q      <= pres_ok;
      btn_prev_q <= flt_in[1];
      // set wins over a same-cycle clear
      pdc_q      <= pds_evt | (pdc_q & ~clr_pdc_i);
      abp_q      <= abp_evt | (abp_q & ~clr_abp_i);
    end
  end

  assign status_o[ST_PDS] = pds_q;
  assign status_o[ST_PDC] = pdc_q;
  assign status_o[ST_ABP] = abp_q;

  assign irq_o = hp_en_i & ((pdc_q & pd_en_i) | (abp_q & ab_en_i));

  hp_blink_div #(.DIV(BLINK_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_o(blink_phase)
  );

  assign ind_cmd[0] = attn_cmd_i;
  assign ind_cmd[1] = pwr_cmd_i;

  for (genvar g = 0; g < N_IND; g++) begin : g_ind
    hp_indicator u_ind (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cmd_i  (ind_cmd[g]),
      .phase_i(blink_phase),
      .led_o  (ind_led[g])
    );
  end

  assign attn_led_o = ind_led[0];
  assign pwr_led_o  = ind_led[1];
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
module hp_slot_ctrl_chk
  import hp_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            power_ok_i,
  input logic            hp_en_i,
  input logic            clr_pdc_i,
  input logic            clr_abp_i,
  input logic [1:0]      attn_cmd_i,
  input logic [1:0]      pwr_cmd_i,
  input logic [ST_W-1:0] status_o,
  input logic            attn_led_o,
  input logic            pwr_led_o,
  input logic            irq_o
);
  // R4
  no_power_no_pds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !power_ok_i |=> !status_o[ST_PDS]);

  // R3
  pds_move_sets_pdc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[ST_PDS] != $past(status_o[ST_PDS])) |-> status_o[ST_PDC]);

  // R6
  pdc_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[ST_PDC] && !clr_pdc_i) |=> status_o[ST_PDC]);

  // R6
  abp_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[ST_ABP] && !clr_abp_i) |=> status_o[ST_ABP]);

  // R7
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (hp_en_i && (status_o[ST_PDC] || status_o[ST_ABP])));

  // R8
  attn_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (attn_cmd_i == CMD_ON) |=> attn_led_o);

  // R8
  pwr_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_cmd_i == CMD_OFF) |=> !pwr_led_o);
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .power_ok_i(power_ok_i),
  .hp_en_i   (hp_en_i),
  .clr_pdc_i (clr_pdc_i),
  .clr_abp_i (clr_abp_i),
  .attn_cmd_i(attn_cmd_i),
  .pwr_cmd_i (pwr_cmd_i),
  .status_o  (status_o),
  .attn_led_o(attn_led_o),
  .pwr_led_o (pwr_led_o),
  .irq_o     (irq_o)
);

// File: tb/tb_hp_slot_ctrl.sv
module tb_hp_slot_ctrl;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned BDIV  = 8;
  localparam int unsigned DEB   = 5;
  localparam int unsigned SETTLE = DEB + 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic presence = 1'b0, power_ok = 1'b0, button = 1'b0;
  logic [CNT_W-1:0] deb = CNT_W'(DEB);
  logic hp_en = 1'b0, pd_en = 1'b0, ab_en = 1'b0;
  logic clr_pdc = 1'b0, clr_abp = 1'b0;
  logic [1:0] attn_cmd = 2'b00, pwr_cmd = 2'b00;
  logic [2:0] status;
  logic attn_led, pwr_led, irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hp_slot_ctrl #(.CNT_W(CNT_W), .BLINK_DIV(BDIV)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .presence_i(presence), .power_ok_i(power_ok),
    .button_i(button), .deb_cycles_i(deb), .hp_en_i(hp_en), .pd_en_i(pd_en),
    .ab_en_i(ab_en), .clr_pdc_i(clr_pdc), .clr_abp_i(clr_abp),
    .attn_cmd_i(attn_cmd), .pwr_cmd_i(pwr_cmd), .status_o(status),
    .attn_led_o(attn_led), .pwr_led_o(pwr_led), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_pdc = 1'b1; clr_abp = 1'b1;
    cyc(1);
    clr_pdc = 1'b0; clr_abp = 1'b0;
    cyc(1);
  endtask

  task automatic t_reset();
    cyc(2);
    chk("R1 status", status, 0);
    chk("R1 attn", attn_led, 0);
    chk("R1 pwr", pwr_led, 0);
    chk("R1 irq", irq, 0);
    rst_ni = 1'b1;
    cyc(2);
  endtask

  task automatic t_glitch();
    power_ok = 1'b1;
    presence = 1'b1;
    cyc(DEB - 2);
    presence = 1'b0;
    cyc(SETTLE);
    chk("R2 short presence glitch", status, 0);
    button = 1'b1;
    cyc(DEB - 2);
    button = 1'b0;
    cyc(SETTLE);
    chk("R2 short button glitch", status, 0);
  endtask

  task automatic t_insert();
    presence = 1'b1;
    cyc(SETTLE);
    chk("R3 pds after insert", status[0], 1);
    chk("R3 pdc after insert", status[1], 1);
    chk("R2 held level accepted", status[2], 0);
  endtask

  task automatic t_clear();
    clr_pdc = 1'b1;
    cyc(1);
    clr_pdc = 1'b0;
    chk("R6 pdc cleared", status[1], 0);
    chk("R6 pds kept", status[0], 1);
    cyc(5);
    chk("R6 pdc stays clear", status[1], 0);
  endtask

  task automatic t_power_loss();
    power_ok = 1'b0;
    cyc(1);
    chk("R4 pds drops with power", status[0], 0);
    chk("R4 pdc set on power loss", status[1], 1);
    clear_all();
    power_ok = 1'b1;
    cyc(2);
    chk("R3 pds back with power", status[0], 1);
    clear_all();
  endtask

  task automatic t_set_wins();
    bit seen = 1'b0;
    clr_pdc = 1'b1;
    presence = 1'b0;
    for (int i = 0; i < SETTLE; i++) begin
      cyc(1);
      if (status[1]) seen = 1'b1;
    end
    chk("R6 event beats held clear", seen, 1);
    chk("R6 clear after event", status[1], 0);
    chk("R4 pds after removal", status[0], 0);
    clr_pdc = 1'b0;
    cyc(1);
  endtask

  task automatic t_remove();
    presence = 1'b1;
    cyc(SETTLE);
    clear_all();
    presence = 1'b0;
    cyc(SETTLE);
    chk("R4 removal pds", status[0], 0);
    chk("R4 removal pdc", status[1], 1);
    clear_all();
  endtask

  task automatic t_button();
    button = 1'b1;
    cyc(SETTLE);
    chk("R5 press sets abp", status[2], 1);
    clr_abp = 1'b1;
    cyc(1);
    clr_abp = 1'b0;
    button = 1'b0;
    cyc(SETTLE);
    chk("R5 release no abp", status[2], 0);
  endtask

  task automatic t_irq();
    presence = 1'b1;
    cyc(SETTLE);
    pd_en = 1'b1; hp_en = 1'b0;
    cyc(1);
    chk("R7 no global enable", irq, 0);
    pd_en = 1'b0; hp_en = 1'b1;
    cyc(1);
    chk("R7 no pd enable", irq, 0);
    pd_en = 1'b1;
    cyc(1);
    chk("R7 pdc irq", irq, 1);
    clear_all();
    chk("R7 irq drops on clear", irq, 0);
    button = 1'b1;
    cyc(SETTLE);
    chk("R7 abp without enable", irq, 0);
    ab_en = 1'b1;
    cyc(1);
    chk("R7 abp irq", irq, 1);
    button = 1'b0;
    clear_all();
    cyc(SETTLE);
    chk("R7 abp irq cleared", irq, 0);
    hp_en = 1'b0; pd_en = 1'b0; ab_en = 1'b0;
  endtask

  task automatic t_indicator();
    attn_cmd = 2'b01;
    cyc(1);
    chk("R8 attn on", attn_led, 1);
    attn_cmd = 2'b00;
    cyc(3);
    chk("R8 attn hold on", attn_led, 1);
    attn_cmd = 2'b11;
    cyc(1);
    chk("R8 attn off", attn_led, 0);
    attn_cmd = 2'b00;
    cyc(3);
    chk("R8 attn hold off", attn_led, 0);
    pwr_cmd = 2'b01;
    cyc(1);
    chk("R8 pwr on", pwr_led, 1);
    chk("R8 attn unaffected", attn_led, 0);
    pwr_cmd = 2'b11;
    cyc(1);
    chk("R8 pwr off", pwr_led, 0);
  endtask

  task automatic t_blink();
    int toggles = 0;
    logic prev;
    pwr_cmd = 2'b10;
    cyc(2);
    pwr_cmd = 2'b00;
    prev = pwr_led;
    for (int i = 0; i < 8 * BDIV; i++) begin
      cyc(1);
      if (pwr_led != prev) toggles++;
      prev = pwr_led;
    end
    chk("R9 blink toggles", toggles, 8);
    chk("R9 attn not blinking", attn_led, 0);
  endtask

  initial begin
    t_reset();
    t_glitch();
    t_insert();
    t_clear();
    t_power_loss();
    t_set_wins();
    t_remove();
    t_button();
    t_irq();
    t_indicator();
    t_blink();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule